// File: doc/BRIEF.md
# Hypervisor Maintenance Interrupt Controller

This block is the hypervisor-facing register file of a list-register based virtual interrupt interface. It holds one bank of registers per physical CPU: a hypervisor control word, a read-only type word, a packed virtual-machine control word and a set of list registers. Each list register describes one virtual interrupt that is queued for a guest. From the list-register contents and the control enables, each bank derives three status words. The empty-list bitmap marks unused entries. The EOI bitmap marks retired entries that asked for notification. The eight-bit maintenance status collects the conditions the hypervisor has asked to be told about.

When a bank's global enable is set and its maintenance status is nonzero, the bank drives its maintenance interrupt output, one wire per CPU. The hypervisor reaches the banks through a simple 32-bit register port. The low nine address bits pick a register, and the bits above them pick the bank. Read data comes back one cycle after the read strobe.

Top module: `hyp_maint_ctrl`

## Requirements
- R1: After reset every stored register of every bank is zero. Each bank therefore reads control 0, VM control 0, maintenance status 0, EOI bitmap 0 and empty bitmap with all NUM_LR low bits set, and every maintenance interrupt output is low.
- R2: Address bits [ADDR_W-1:9] select the bank. A write reaches only the selected bank. A bank number of NUM_CPU or above reads as zero and its writes change nothing.
- R3: The type register (offset 0x004) reads 0x44000000 ORed with NUM_LR-1.
- R4: The VM control register (offset 0x008) stores only these fields: priority mask [31:27], binary point [23:21], aliased binary point [20:18], EOI mode [9], common binary point [4], FIQ enable [3], ack control [2], group-1 enable [1] and group-0 enable [0]. All other bits read zero.
- R5: The control register (offset 0x000) stores enable bits [7:0] and the EOI count [31:27]; bits [26:8] read zero. Enable bits: [0] global enable, [1] underflow, [2] entry-not-present, [3] no-pending, [4] group-0 enabled, [5] group-0 disabled, [6] group-1 enabled, [7] group-1 disabled.
- R6: List register i sits at offset 0x100+4*i and stores all 32 bits. Its state is [29:28] (0 invalid, 1 pending, 2 active, 3 pending and active) and its EOI-request flag is bit 19.
- R7: The empty bitmap (offset 0x030) has bit i set exactly when list register i has state 0. Bits at or above NUM_LR read zero.
- R8: The EOI bitmap (offset 0x020) has bit i set exactly when list register i has state 0 and its bit 19 set.
- R9: In the maintenance status word (offset 0x010), bit 7 = control[7] AND NOT group-1 enable; bit 6 = control[6] AND group-1 enable; bit 5 = control[5] AND NOT group-0 enable; bit 4 = control[4] AND group-0 enable.
- R10: Bit 3 = control[3] AND no entry has state 1 or 3. Bit 2 = control[2] AND EOI count nonzero. Bit 1 = control[1] AND at most one entry has nonzero state. Bits [31:8] read zero.
- R11: Bit 0 of the maintenance status is set when any EOI bitmap bit is set.
- R12: The maintenance interrupt of a bank is a register that is loaded on each clock with (global enable AND maintenance status nonzero). It therefore changes one cycle after the register change that causes it.
- R13: Writes to the active-priority offset 0x0F0, to unimplemented offsets and to list offsets at or beyond NUM_LR change no state. Such offsets read zero.
- R14: Read data appears on the cycle after the read strobe. When a read and a write to the same register fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address; [8:0] register offset, [ADDR_W-1:9] bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| maint_irq_o | output | NUM_CPU | Maintenance interrupt, one per bank |

## Verification
A register update and a read of the same register can land in the same cycle. The bench provokes this by asserting both strobes on the control offset of one bank. It expects the old contents on that cycle and the new contents on the repeat. A list-register or control write also falls in the same cycle as the interrupt re-evaluation. The bench samples the interrupt at the cycle of the write, where it expects the old level, and one cycle later, where it expects the new level. The main sweep runs all 256 enable patterns against 32 list-state configurations. Each maintenance status and interrupt value is recomputed arithmetically from the stored words.

// File: rtl/hmic_pkg.sv
package hmic_pkg;

   localparam int unsigned DATA_W = 32;
   localparam int unsigned OFF_W  = 9;

   // register offsets inside one bank
   localparam logic [OFF_W-1:0] OFF_CTRL  = 9'h000;
   localparam logic [OFF_W-1:0] OFF_TYPE  = 9'h004;
   localparam logic [OFF_W-1:0] OFF_VMCTL = 9'h008;
   localparam logic [OFF_W-1:0] OFF_MSTAT = 9'h010;
   localparam logic [OFF_W-1:0] OFF_EOIBM = 9'h020;
   localparam logic [OFF_W-1:0] OFF_EMPTY = 9'h030;
   localparam logic [OFF_W-1:0] OFF_APRIO = 9'h0F0;

   // control word: enables [7:0], EOI count [31:27]
   localparam logic [DATA_W-1:0] CTRL_MASK = 32'hF800_00FF;
   localparam int unsigned CTRL_EN      = 0;
   localparam int unsigned CTRL_UNDER   = 1;
   localparam int unsigned CTRL_NOTPRES = 2;
   localparam int unsigned CTRL_NOPEND  = 3;
   localparam int unsigned CTRL_G0ON    = 4;
   localparam int unsigned CTRL_G0OFF   = 5;
   localparam int unsigned CTRL_G1ON    = 6;
   localparam int unsigned CTRL_G1OFF   = 7;
   localparam int unsigned CTRL_CNT_LSB = 27;

   // VM control word field mask and group enable positions
   localparam logic [DATA_W-1:0] VMCTL_MASK = 32'hF8FC_021F;
   localparam int unsigned VM_G0EN = 0;
   localparam int unsigned VM_G1EN = 1;

   // list register fields
   localparam int unsigned LR_STATE_LSB = 28;
   localparam int unsigned LR_EOIREQ    = 19;

   localparam logic [DATA_W-1:0] TYPE_BASE = 32'h4400_0000;

   typedef enum logic [1:0] {
      LR_INVALID = 2'd0,
      LR_PENDING = 2'd1,
      LR_ACTIVE  = 2'd2,
      LR_PENDACT = 2'd3
   } lr_state_e;

endpackage

// File: rtl/hmic_lr_status.sv
module hmic_lr_status
   import hmic_pkg::*;
#(
   parameter int NUM_LR = 4
) (
   input  logic [NUM_LR-1:0][1:0] state_i,
   input  logic [NUM_LR-1:0]      eoireq_i,
   output logic [NUM_LR-1:0]      empty_o,
   output logic [NUM_LR-1:0]      eoibm_o,
   output logic                   none_pending_o,
   output logic                   few_valid_o
);

   localparam int CNT_W = $clog2(NUM_LR + 1) + 1;

   logic [NUM_LR-1:0] pend;
   logic [NUM_LR-1:0] valid;
   logic [CNT_W-1:0]  valid_cnt;

   for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
      lr_state_e st;
      assign st        = lr_state_e'(state_i[i]);
      assign empty_o[i] = (st == LR_INVALID);
      assign valid[i]   = (st != LR_INVALID);
      assign pend[i]    = (st == LR_PENDING) || (st == LR_PENDACT);
      assign eoibm_o[i] = (st == LR_INVALID) && eoireq_i[i];
   end

   always_comb begin
      valid_cnt = '0;
      for (int i = 0; i < NUM_LR; i++) begin
         valid_cnt = valid_cnt + {{(CNT_W-1){1'b0}}, valid[i]};
      end
   end

   assign none_pending_o = ~|pend;
   assign few_valid_o    = (valid_cnt <= CNT_W'(1));

endmodule

// File: rtl/hmic_bank.sv
module hmic_bank
   import hmic_pkg::*;
#(
   parameter int NUM_LR = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   localparam logic [DATA_W-1:0] TYPE_VAL = TYPE_BASE | DATA_W'(NUM_LR - 1);

   logic [DATA_W-1:0]             ctrl_q;
   logic [DATA_W-1:0]             vmctl_q;
   logic [NUM_LR-1:0][DATA_W-1:0] lr_q;
   logic                          irq_q;

   logic                          is_lr;
   logic [5:0]                    lr_idx;
   logic [NUM_LR-1:0][1:0]        lr_state;
   logic [NUM_LR-1:0]             lr_eoireq;
   logic [NUM_LR-1:0]             empty_bm;
   logic [NUM_LR-1:0]             eoi_bm;
   logic                          none_pend;
   logic                          few_valid;
   logic [7:0]                    mstat;

   assign lr_idx = off_i[7:2];
   assign is_lr  = off_i[8] && (off_i[1:0] == 2'b00) && ({1'b0, lr_idx} < 7'(NUM_LR));

   // ---------------- storage ----------------
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         vmctl_q <= '0;
      end else if (wr_i) begin
         if (off_i == OFF_CTRL)  ctrl_q  <= wdata_i & CTRL_MASK;
         if (off_i == OFF_VMCTL) vmctl_q <= wdata_i & VMCTL_MASK;
      end
   end

   for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            lr_q[i] <= '0;
         end else if (wr_i && is_lr && (lr_idx == 6'(i))) begin
            lr_q[i] <= wdata_i;
         end
      end
      assign lr_state[i]  = lr_q[i][LR_STATE_LSB +: 2];
      assign lr_eoireq[i] = lr_q[i][LR_EOIREQ];
   end

   // ---------------- derived list status ----------------
   hmic_lr_status #(
      .NUM_LR (NUM_LR)
   ) i_lr_status (
      .state_i        (lr_state),
      .eoireq_i       (lr_eoireq),
      .empty_o        (empty_bm),
      .eoibm_o        (eoi_bm),
      .none_pending_o (none_pend),
      .few_valid_o    (few_valid)
   );

   // ---------------- maintenance status ----------------
   always_comb begin
      mstat    = '0;
      mstat[7] = ctrl_q[CTRL_G1OFF]   && !vmctl_q[VM_G1EN];
      mstat[6] = ctrl_q[CTRL_G1ON]    &&  vmctl_q[VM_G1EN];
      mstat[5] = ctrl_q[CTRL_G0OFF]   && !vmctl_q[VM_G0EN];
      mstat[4] = ctrl_q[CTRL_G0ON]    &&  vmctl_q[VM_G0EN];
      mstat[3] = ctrl_q[CTRL_NOPEND]  && none_pend;
      mstat[2] = ctrl_q[CTRL_NOTPRES] && (ctrl_q[CTRL_CNT_LSB +: 5] != 5'd0);
      mstat[1] = ctrl_q[CTRL_UNDER]   && few_valid;
      mstat[0] = |eoi_bm;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= ctrl_q[CTRL_EN] && (mstat != 8'd0);
   end
   assign irq_o = irq_q;

   // ---------------- read decode ----------------
   always_comb begin
      rdata_o = '0;
      case (off_i)
         OFF_CTRL:  rdata_o = ctrl_q;
         OFF_TYPE:  rdata_o = TYPE_VAL;
         OFF_VMCTL: rdata_o = vmctl_q;
         OFF_MSTAT: rdata_o = DATA_W'(mstat);
         OFF_EOIBM: rdata_o = DATA_W'(eoi_bm);
         OFF_EMPTY: rdata_o = DATA_W'(empty_bm);
         default: begin
            for (int i = 0; i < NUM_LR; i++) begin
               if (is_lr && (lr_idx == 6'(i))) rdata_o = lr_q[i];
            end
         end
      endcase
   end

   // ---------------- assertions ----------------
   // R12
   irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q[CTRL_EN] |=> !irq_o);
   // R12
   irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[CTRL_EN] && (mstat != 8'd0)) |=> irq_o);
   // R8
   eoi_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((eoi_bm & ~empty_bm) == '0));
   // R7
   empty_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      few_valid == ($countones(empty_bm) >= NUM_LR - 1));
   // R11
   eoi_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_bm != '0) |-> mstat[0]);
   // R13
   aprio_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && (off_i == OFF_APRIO)) |=> ($stable(ctrl_q) && $stable(vmctl_q) && $stable(lr_q)));

endmodule

// File: rtl/hyp_maint_ctrl.sv
module hyp_maint_ctrl
   import hmic_pkg::*;
#(
   parameter int NUM_CPU = 3,
   parameter int NUM_LR  = 4,
   parameter int BANK_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   parameter int ADDR_W  = OFF_W + BANK_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CPU-1:0] maint_irq_o
);

   localparam logic [BANK_W:0] BANK_LIMIT = NUM_CPU[BANK_W:0];
   localparam logic [DATA_W-1:0] TYPE_VAL = TYPE_BASE | DATA_W'(NUM_LR - 1);

   // elaboration-time parameter checks
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..8");
   end
   if (NUM_LR < 1 || NUM_LR > 32) begin : g_bad_lr
      $error("NUM_LR must lie in 1..32");
   end
   if (ADDR_W != OFF_W + BANK_W) begin : g_bad_addr
      $error("ADDR_W must equal register offset width plus BANK_W");
   end

   logic [BANK_W-1:0]              bank_sel;
   logic [OFF_W-1:0]               reg_off;
   logic                           bank_hit;
   logic [NUM_CPU-1:0][DATA_W-1:0] bank_rdata;
   logic [DATA_W-1:0]              rd_mux;
   logic [DATA_W-1:0]              rdata_q;

   assign bank_sel = bus_addr_i[ADDR_W-1:OFF_W];
   assign reg_off  = bus_addr_i[OFF_W-1:0];
   assign bank_hit = {1'b0, bank_sel} < BANK_LIMIT;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      hmic_bank #(
         .NUM_LR (NUM_LR)
      ) i_bank (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .wr_i    (bus_wr_i && bank_hit && (bank_sel == BANK_W'(c))),
         .off_i   (reg_off),
         .wdata_i (bus_wdata_i),
         .rdata_o (bank_rdata[c]),
         .irq_o   (maint_irq_o[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (bank_hit && (bank_sel == BANK_W'(c))) rd_mux = bank_rdata[c];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_mux;
   end
   assign bus_rdata_o = rdata_q;

   // R3
   type_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bank_hit && (reg_off == OFF_TYPE)) |=> (bus_rdata_o == TYPE_VAL));
   // R2
   bad_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && !bank_hit) |=> (bus_rdata_o == '0));
   // R14
   hold_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/test_hyp_maint_ctrl.sv
module test_hyp_maint_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NCPU   = 3;
   localparam int NLR    = 4;
   localparam int BW     = 2;
   localparam int AW     = 9 + BW;

   localparam logic [8:0] A_CTRL  = 9'h000;
   localparam logic [8:0] A_TYPE  = 9'h004;
   localparam logic [8:0] A_VMCTL = 9'h008;
   localparam logic [8:0] A_MSTAT = 9'h010;
   localparam logic [8:0] A_EOIBM = 9'h020;
   localparam logic [8:0] A_EMPTY = 9'h030;
   localparam logic [8:0] A_APRIO = 9'h0F0;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr = 1'b0;
   logic            rd = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NCPU-1:0] irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] lr_model [NLR];

   always #(CLK_PERIOD/2) clk = ~clk;

   hyp_maint_ctrl #(.NUM_CPU(NCPU), .NUM_LR(NLR)) i_hyp_maint_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .maint_irq_o (irq)
   );

   function automatic logic [AW-1:0] mk(input int bank, input logic [8:0] off);
      return {BW'(bank), off};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic bus_rw(input logic [AW-1:0] a, input logic [31:0] dw, output logic [31:0] dr);
      @(negedge clk);
      rd = 1'b1; wr = 1'b1; addr = a; wdata = dw;
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
      dr = rdata;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic logic [31:0] lr_word(input int k, input int i);
      logic [1:0] st;
      logic       eo;
      if (k[4]) st = (i == (k & 3)) ? 2'((k >> 2) & 3) : 2'd0;
      else      st = 2'((k >> i) & 3) ^ 2'(i);
      eo = 1'(k ^ i);
      return {2'b00, st, 8'h00, eo, 9'h000, 10'(k * 4 + i)};
   endfunction

   function automatic logic [7:0] exp_mstat(input logic [31:0] c, input logic [1:0] g);
      logic [7:0] m;
      int nvalid;
      logic anypend, anyeoi;
      nvalid = 0; anypend = 1'b0; anyeoi = 1'b0;
      for (int i = 0; i < NLR; i++) begin
         if (lr_model[i][29:28] != 2'd0) nvalid++;
         if (lr_model[i][28]) anypend = 1'b1;
         if (lr_model[i][29:28] == 2'd0 && lr_model[i][19]) anyeoi = 1'b1;
      end
      m[7] = c[7] & ~g[1];
      m[6] = c[6] &  g[1];
      m[5] = c[5] & ~g[0];
      m[4] = c[4] &  g[0];
      m[3] = c[3] & ~anypend;
      m[2] = c[2] & (c[31:27] != 5'd0);
      m[1] = c[1] & (nvalid <= 1);
      m[0] = anyeoi;
      return m;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [31:0] cw;
      logic [3:0]  e_empty, e_eoi;
      logic [7:0]  m;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", 32'(irq), 32'd0);
      for (int b = 0; b < NCPU; b++) begin
         bus_read(mk(b, A_CTRL), d);  chk("R1 ctrl", d, 32'd0);
         bus_read(mk(b, A_VMCTL), d); chk("R1 vmctl", d, 32'd0);
         bus_read(mk(b, A_MSTAT), d); chk("R1 mstat", d, 32'd0);
         bus_read(mk(b, A_EOIBM), d); chk("R1 eoibm", d, 32'd0);
         bus_read(mk(b, A_EMPTY), d); chk("R1 empty", d, 32'h0000_000F);
         // R3
         bus_read(mk(b, A_TYPE), d);  chk("R3 type", d, 32'h4400_0000 | 32'(NLR - 1));
      end

      // R4 VM control field packing
      bus_write(mk(1, A_VMCTL), 32'hFFFF_FFFF);
      bus_read(mk(1, A_VMCTL), d);
      chk("R4 vmctl all ones", d, 32'hF800_0000 | 32'h00E0_0000 | 32'h001C_0000 | 32'h200 | 32'h1F);
      bus_write(mk(1, A_VMCTL), 32'h5A5A_5A5A);
      bus_read(mk(1, A_VMCTL), d);
      chk("R4 vmctl pattern", d, 32'h5A5A_5A5A & 32'hF8FC_021F);

      // R5 control storage
      bus_write(mk(1, A_CTRL), 32'hFFFF_FFFF);
      bus_read(mk(1, A_CTRL), d);
      chk("R5 ctrl mask", d, 32'hF800_00FF);

      // R6 list registers
      for (int i = 0; i < NLR; i++) bus_write(mk(1, 9'h100 + 9'(4 * i)), 32'hA000_0000 + 32'(i * 32'h0101_0101));
      for (int i = 0; i < NLR; i++) begin
         bus_read(mk(1, 9'h100 + 9'(4 * i)), d);
         chk("R6 lr readback", d, 32'hA000_0000 + 32'(i * 32'h0101_0101));
      end

      // R13 ignored writes
      bus_write(mk(1, A_APRIO), 32'h0);
      bus_write(mk(1, 9'h0FC), 32'h0);
      bus_write(mk(1, 9'h100 + 9'(4 * NLR)), 32'h0);
      bus_read(mk(1, A_CTRL), d);  chk("R13 ctrl after aprio", d, 32'hF800_00FF);
      bus_read(mk(1, A_VMCTL), d); chk("R13 vmctl after aprio", d, 32'h5A5A_5A5A & 32'hF8FC_021F);
      bus_read(mk(1, A_APRIO), d); chk("R13 aprio reads zero", d, 32'd0);
      bus_read(mk(1, 9'h100 + 9'(4 * NLR)), d); chk("R13 lr beyond", d, 32'd0);
      bus_read(mk(1, 9'h100 + 9'(4 * (NLR - 1))), d);
      chk("R13 last lr kept", d, 32'hA000_0000 + 32'((NLR - 1) * 32'h0101_0101));

      // R2 bank isolation and absent bank
      bus_read(mk(0, A_CTRL), d); chk("R2 bank0 untouched", d, 32'd0);
      bus_read(mk(2, 9'h100), d); chk("R2 bank2 lr untouched", d, 32'd0);
      bus_write(mk(3, A_CTRL), 32'hFFFF_FFFF);
      bus_read(mk(3, A_CTRL), d); chk("R2 absent bank", d, 32'd0);
      bus_read(mk(3, A_TYPE), d); chk("R2 absent bank type", d, 32'd0);
      bus_read(mk(0, A_CTRL), d); chk("R2 absent write ignored b0", d, 32'd0);
      bus_read(mk(2, A_CTRL), d); chk("R2 absent write ignored b2", d, 32'd0);
      bus_write(mk(1, A_CTRL), 32'h0);
      for (int i = 0; i < NLR; i++) bus_write(mk(1, 9'h100 + 9'(4 * i)), 32'h0);

      // R14 read in the same cycle as a write
      bus_rw(mk(2, A_CTRL), 32'h0000_0012, d); chk("R14 old value", d, 32'd0);
      bus_rw(mk(2, A_CTRL), 32'h0000_0000, d); chk("R14 new value", d, 32'h0000_0012);

      // R12 interrupt latency on bank 2 (all lists empty -> underflow condition)
      @(negedge clk);
      wr = 1'b1; addr = mk(2, A_CTRL); wdata = 32'h0000_0003;
      @(negedge clk);
      wr = 1'b0;
      chk("R12 irq not yet", 32'(irq[2]), 32'd0);
      @(negedge clk);
      chk("R12 irq raised", 32'(irq[2]), 32'd1);
      chk("R12 other banks quiet", 32'(irq[1:0]), 32'd0);
      @(negedge clk);
      wr = 1'b1; addr = mk(2, A_CTRL); wdata = 32'h0000_0002;
      @(negedge clk);
      wr = 1'b0;
      chk("R12 irq held one cycle", 32'(irq[2]), 32'd1);
      @(negedge clk);
      chk("R12 irq dropped without enable", 32'(irq[2]), 32'd0);
      bus_write(mk(2, A_CTRL), 32'h0);

      // R7..R12 sweep on bank 0
      for (int k = 0; k < 32; k++) begin
         for (int i = 0; i < NLR; i++) begin
            lr_model[i] = lr_word(k, i);
            bus_write(mk(0, 9'h100 + 9'(4 * i)), lr_model[i]);
         end
         bus_write(mk(0, A_VMCTL), {30'd0, 2'(k)});
         e_empty = '0; e_eoi = '0;
         for (int i = 0; i < NLR; i++) begin
            e_empty[i] = (lr_model[i][29:28] == 2'd0);
            e_eoi[i]   = e_empty[i] & lr_model[i][19];
         end
         bus_read(mk(0, A_EMPTY), d); chk("R7 empty bitmap", d, 32'(e_empty));
         bus_read(mk(0, A_EOIBM), d); chk("R8 eoi bitmap", d, 32'(e_eoi));
         for (int h = 0; h < 256; h++) begin
            cw = {(k[2] ? 5'd3 : 5'd0), 19'd0, 8'(h)};
            bus_write(mk(0, A_CTRL), cw);
            bus_read(mk(0, A_MSTAT), d);
            m = exp_mstat(cw, 2'(k));
            chk("R9 R10 R11 mstat", d, 32'(m));
            chk("R12 irq sweep", 32'(irq[0]), 32'(cw[0] && (m != 8'd0)));
         end
      end

      finish_run();
   end

endmodule